// File: doc/BRIEF.md
# Radix-4 Parallel Butterfly Stage

This block is one pipelined stage of a fixed-point FFT that takes four complex samples per clock. On every cycle it accepts four complex samples with four complex twiddle factors and a valid flag. It multiplies each sample by its own twiddle, forms the radix-4 butterfly over the four products, and reduces the result to the output width chosen by a compile-time growth policy. Four complex results and a matching valid flag come out three cycles later.

Three growth policies are offered. In free growth the output is two bits wider than the input and nothing is discarded. In fixed shift the output keeps the input width and each result is shifted right by two bits. In capped growth the stage widens by two bits while the result still fits a 27-bit ceiling, and otherwise holds at the ceiling and shifts off the excess. A parameter picks forward or inverse transform. A full N-point transform chains log4(N) such stages with reordering between them; for example, 64 points take three stages and, with free growth, add six bits in total. The reordering and the twiddle source are outside this block.

Top module: `r4_stage`

## Requirements
- R1: Every cycle with `in_vld` high yields exactly one cycle with `out_vld` high, three clock edges later, carrying that cycle's results; the five instantiated variants share this timing.
- R2: Twiddles are signed 18-bit values with 16 fractional bits (65536 is +1). The complex product of a sample and its twiddle is floored by dropping the 16 fractional bits, then wrapped to the sample width. A twiddle of exactly +1 returns the sample unchanged one cycle later.
- R3: Lane `k` of every bus sits at bits `[k*W +: W]`. Forward results, with y the four products, are: X0 = y0+y1+y2+y3, X1 = y0 - j*y1 - y2 + j*y3, X2 = y0 - y1 + y2 - y3 and X3 = y0 + j*y1 - y2 - j*y3. The four outputs always sum to four times y0.
- R4: With `INVERSE` set, each twiddle's imaginary part is negated before the multiply, and the signs of the ±j terms in X1 and X3 are exchanged.
- R5: In free growth (`GROWTH` = 0), the output width is `SMP_W`+2 and the butterfly result is passed on with no bits removed.
- R6: In fixed shift (`GROWTH` = 1), the output width equals `SMP_W`. Each butterfly result is shifted right arithmetically by two bits, which floors it, and the sign of every output matches the sign of the unshifted result.
- R7: In capped growth (`GROWTH` = 2) with `SMP_W`+2 at most 27, the output matches free growth.
- R8: In capped growth with `SMP_W`+2 above 27, the output width is 27. The butterfly result is shifted right arithmetically by `SMP_W`+2-27 bits.
- R9: While `rst_n` is low, `out_vld` stays low.
- R10: Cycles with `in_vld` low produce no `out_vld`, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| in_vld | input | 1 | Input lanes carry a sample set this cycle |
| in_re | input | 4*SMP_W | Real parts of the four samples |
| in_im | input | 4*SMP_W | Imaginary parts of the four samples |
| tw_re | input | 4*TWID_W | Real parts of the four twiddles |
| tw_im | input | 4*TWID_W | Imaginary parts of the four twiddles |
| out_vld | output | 1 | Output lanes carry results this cycle |
| out_re | output | 4*RES_W | Real parts of the four results |
| out_im | output | 4*RES_W | Imaginary parts of the four results |

## Verification
The bench runs five instances side by side: free growth forward, fixed shift forward, free growth inverse, capped growth below the ceiling, and capped growth above the ceiling with a 26-bit input. A single-lane impulse on lane 1 separates forward from inverse, because a design that left the ±j arms unswapped would give the same X1 for both directions. Full-scale negative samples times a twiddle of -1 exercise the product wrap, and a design that saturated or widened there would differ in the top bit. Small odd values under a 45-degree twiddle and under the two-bit shift expose rounding where flooring is required. Gaps in `in_vld` and a long sweep over mixed table and arbitrary twiddles expose valid-pipeline slips, which would show up as missing, extra or misaligned results.

// File: rtl/r4s_pkg.sv
package r4s_pkg;

   localparam int LANES  = 4;
   localparam int LOG2_R = 2;

   typedef enum logic [1:0] {
      GROW_FREE   = 2'd0,
      SHIFT_EACH  = 2'd1,
      GROW_CAPPED = 2'd2
   } growth_e;

   // Width of the stage result for a given input width and policy.
   function automatic int stage_out_w(input int in_w, input growth_e mode, input int cap);
      int grown;
      grown = in_w + LOG2_R;
      case (mode)
         SHIFT_EACH:  return in_w;
         GROW_CAPPED: return (grown > cap) ? cap : grown;
         default:     return grown;
      endcase
   endfunction

endpackage

// File: rtl/r4s_cmul.sv
module r4s_cmul #(
   parameter int SW   = 16,
   parameter int TW   = 18,
   parameter int TF   = 16,
   parameter bit CONJ = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [SW-1:0] smp_re,
   input  logic signed [SW-1:0] smp_im,
   input  logic signed [TW-1:0] tw_re,
   input  logic signed [TW-1:0] tw_im,
   output logic signed [SW-1:0] prod_re,
   output logic signed [SW-1:0] prod_im
);
   // One extra bit so that negating the most negative twiddle cannot wrap.
   localparam int EW = TW + 1;
   localparam int PW = SW + EW + 1;
   localparam logic signed [TW-1:0] W_ONE = TW'(64'sd1 <<< TF);

   logic signed [EW-1:0] w_r, w_i;
   logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
   logic signed [PW-1:0] acc_re_d, acc_im_d, acc_re_q, acc_im_q;

   assign w_r = EW'(tw_re);

   generate
      if (CONJ) begin : g_conj
         assign w_i = -EW'(tw_im);
      end else begin : g_plain
         assign w_i = EW'(tw_im);
      end
   endgenerate

   always_comb begin
      m_rr     = PW'(smp_re) * PW'(w_r);
      m_ii     = PW'(smp_im) * PW'(w_i);
      m_ri     = PW'(smp_re) * PW'(w_i);
      m_ir     = PW'(smp_im) * PW'(w_r);
      acc_re_d = m_rr - m_ii;
      acc_im_d = m_ri + m_ir;
   end

   always_ff @(posedge clk) begin
      acc_re_q <= acc_re_d;
      acc_im_q <= acc_im_d;
   end

   // Floor away the fractional twiddle bits, keep the sample range.
   assign prod_re = SW'(acc_re_q >>> TF);
   assign prod_im = SW'(acc_im_q >>> TF);

   // R2: a unit twiddle hands the sample through unchanged.
   p_unity_tw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tw_re) == W_ONE && $past(tw_im) == '0)
      |-> (prod_re == $past(smp_re) && prod_im == $past(smp_im)));

endmodule

// File: rtl/r4s_bfly.sv
module r4s_bfly
   import r4s_pkg::*;
#(
   parameter  int SW  = 16,
   parameter  bit INV = 1'b0,
   localparam int FW  = SW + LOG2_R
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [SW-1:0] y_re [LANES],
   input  logic signed [SW-1:0] y_im [LANES],
   output logic signed [FW-1:0] x_re [LANES],
   output logic signed [FW-1:0] x_im [LANES]
);
   localparam int SUMW = FW + 2;

   logic signed [FW-1:0] e_re [LANES];
   logic signed [FW-1:0] e_im [LANES];
   logic signed [FW-1:0] a_re, a_im, b_re, b_im, c_re, c_im, d_re, d_im;
   logic signed [FW-1:0] mj_re, mj_im, pj_re, pj_im;
   logic signed [FW-1:0] k1_re, k1_im, k3_re, k3_im;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_ext
         assign e_re[g] = FW'(y_re[g]);
         assign e_im[g] = FW'(y_im[g]);
      end
   endgenerate

   always_comb begin
      a_re  = e_re[0] + e_re[2];
      a_im  = e_im[0] + e_im[2];
      b_re  = e_re[0] - e_re[2];
      b_im  = e_im[0] - e_im[2];
      c_re  = e_re[1] + e_re[3];
      c_im  = e_im[1] + e_im[3];
      d_re  = e_re[1] - e_re[3];
      d_im  = e_im[1] - e_im[3];
      // b - j*d and b + j*d
      mj_re = b_re + d_im;
      mj_im = b_im - d_re;
      pj_re = b_re - d_im;
      pj_im = b_im + d_re;
   end

   // Direction only decides which odd output takes which rotation arm.
   generate
      if (INV) begin : g_inv
         assign k1_re = pj_re;
         assign k1_im = pj_im;
         assign k3_re = mj_re;
         assign k3_im = mj_im;
      end else begin : g_fwd
         assign k1_re = mj_re;
         assign k1_im = mj_im;
         assign k3_re = pj_re;
         assign k3_im = pj_im;
      end
   endgenerate

   always_ff @(posedge clk) begin
      x_re[0] <= a_re + c_re;
      x_im[0] <= a_im + c_im;
      x_re[1] <= k1_re;
      x_im[1] <= k1_im;
      x_re[2] <= a_re - c_re;
      x_im[2] <= a_im - c_im;
      x_re[3] <= k3_re;
      x_im[3] <= k3_im;
   end

   logic signed [SUMW-1:0] xs_re, xs_im, y4_re, y4_im;
   assign xs_re = SUMW'(x_re[0]) + SUMW'(x_re[1]) + SUMW'(x_re[2]) + SUMW'(x_re[3]);
   assign xs_im = SUMW'(x_im[0]) + SUMW'(x_im[1]) + SUMW'(x_im[2]) + SUMW'(x_im[3]);
   assign y4_re = SUMW'(y_re[0]) <<< 2;
   assign y4_im = SUMW'(y_im[0]) <<< 2;

   // R3: the four bins together sum back to four times the first product.
   p_bin_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xs_re == $past(y4_re)) && (xs_im == $past(y4_im)));

endmodule

// File: rtl/r4s_shift.sv
module r4s_shift
   import r4s_pkg::*;
#(
   parameter int FW = 18,
   parameter int OW = 18,
   parameter int SH = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [FW-1:0] x_re [LANES],
   input  logic signed [FW-1:0] x_im [LANES],
   output logic signed [OW-1:0] o_re [LANES],
   output logic signed [OW-1:0] o_im [LANES]
);
   generate
      if (OW < FW - SH) begin : g_bad_fit
         $error("r4s_shift: result width cannot hold the shifted value");
      end
      if (SH < 0) begin : g_bad_sh
         $error("r4s_shift: negative shift");
      end

      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic signed [OW-1:0] q_re, q_im;
         if (SH == 0) begin : g_keep
            always_ff @(posedge clk) begin
               q_re <= OW'(x_re[g]);
               q_im <= OW'(x_im[g]);
            end
         end else begin : g_cut
            always_ff @(posedge clk) begin
               q_re <= OW'(x_re[g] >>> SH);
               q_im <= OW'(x_im[g] >>> SH);
            end
         end
         assign o_re[g] = q_re;
         assign o_im[g] = q_im;

         // R6: flooring shift never flips the sign of a result.
         p_sign_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (o_re[g][OW-1] == $past(x_re[g][FW-1])) &&
            (o_im[g][OW-1] == $past(x_im[g][FW-1])));
      end
   endgenerate

endmodule

// File: rtl/r4_stage.sv
module r4_stage
   import r4s_pkg::*;
#(
   parameter  int      SMP_W     = 16,
   parameter  growth_e GROWTH    = GROW_FREE,
   parameter  bit      INVERSE   = 1'b0,
   parameter  int      CAP_W     = 27,
   parameter  int      TWID_W    = 18,
   parameter  int      TWID_FRAC = 16,
   localparam int      FULL_W    = SMP_W + LOG2_R,
   localparam int      RES_W     = stage_out_w(SMP_W, GROWTH, CAP_W),
   localparam int      DROP      = FULL_W - RES_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_vld,
   input  logic [LANES*SMP_W-1:0]    in_re,
   input  logic [LANES*SMP_W-1:0]    in_im,
   input  logic [LANES*TWID_W-1:0]   tw_re,
   input  logic [LANES*TWID_W-1:0]   tw_im,
   output logic                      out_vld,
   output logic [LANES*RES_W-1:0]    out_re,
   output logic [LANES*RES_W-1:0]    out_im
);
   localparam int LAT = 3;

   // Elaboration-time parameter checks.
   generate
      if (SMP_W < 4) begin : g_bad_smp
         $error("r4_stage: SMP_W too small");
      end
      if (TWID_FRAC > TWID_W - 2) begin : g_bad_tw
         $error("r4_stage: twiddle needs two integer bits");
      end
      if (GROWTH == GROW_CAPPED && SMP_W > CAP_W) begin : g_bad_cap
         $error("r4_stage: input wider than the growth ceiling");
      end
      if (DROP < 0 || DROP > LOG2_R) begin : g_bad_drop
         $error("r4_stage: inconsistent growth policy");
      end
   endgenerate

   logic signed [SMP_W-1:0]  s_re [LANES];
   logic signed [SMP_W-1:0]  s_im [LANES];
   logic signed [TWID_W-1:0] w_re [LANES];
   logic signed [TWID_W-1:0] w_im [LANES];
   logic signed [SMP_W-1:0]  p_re [LANES];
   logic signed [SMP_W-1:0]  p_im [LANES];
   logic signed [FULL_W-1:0] f_re [LANES];
   logic signed [FULL_W-1:0] f_im [LANES];
   logic signed [RES_W-1:0]  r_re [LANES];
   logic signed [RES_W-1:0]  r_im [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign s_re[g] = in_re[g*SMP_W +: SMP_W];
         assign s_im[g] = in_im[g*SMP_W +: SMP_W];
         assign w_re[g] = tw_re[g*TWID_W +: TWID_W];
         assign w_im[g] = tw_im[g*TWID_W +: TWID_W];

         r4s_cmul #(
            .SW   (SMP_W),
            .TW   (TWID_W),
            .TF   (TWID_FRAC),
            .CONJ (INVERSE)
         ) u_cmul (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_re  (s_re[g]),
            .smp_im  (s_im[g]),
            .tw_re   (w_re[g]),
            .tw_im   (w_im[g]),
            .prod_re (p_re[g]),
            .prod_im (p_im[g])
         );

         assign out_re[g*RES_W +: RES_W] = r_re[g];
         assign out_im[g*RES_W +: RES_W] = r_im[g];
      end
   endgenerate

   r4s_bfly #(
      .SW  (SMP_W),
      .INV (INVERSE)
   ) u_bfly (
      .clk   (clk),
      .rst_n (rst_n),
      .y_re  (p_re),
      .y_im  (p_im),
      .x_re  (f_re),
      .x_im  (f_im)
   );

   r4s_shift #(
      .FW (FULL_W),
      .OW (RES_W),
      .SH (DROP)
   ) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .x_re  (f_re),
      .x_im  (f_im),
      .o_re  (r_re),
      .o_im  (r_im)
   );

   // Valid travels alongside the three data registers.
   logic [LAT-1:0] vld_sr;
   always_ff @(posedge clk) begin
      if (!rst_n) vld_sr <= '0;
      else        vld_sr <= {vld_sr[LAT-2:0], in_vld};
   end
   assign out_vld = vld_sr[LAT-1];

   // Cycles since reset release, saturating, to arm the latency check.
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1: out_vld is in_vld delayed by exactly three edges.
   p_vld_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_vld == $past(in_vld, 3)));

endmodule

// File: tb/tb_r4_stage.sv
module tb_r4_stage;
   import r4s_pkg::*;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n;
   logic         vld;
   logic [63:0]  a_re, a_im;
   logic [103:0] b_re, b_im;
   logic [71:0]  t_re, t_im;

   logic         va, vs, vi, vl, vc;
   logic [71:0]  oa_re, oa_im, oi_re, oi_im, ol_re, ol_im;
   logic [63:0]  os_re, os_im;
   logic [107:0] oc_re, oc_im;

   r4_stage #(.SMP_W(16), .GROWTH(GROW_FREE), .INVERSE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_re(a_re), .in_im(a_im),
      .tw_re(t_re), .tw_im(t_im), .out_vld(va), .out_re(oa_re), .out_im(oa_im));

   r4_stage #(.SMP_W(16), .GROWTH(SHIFT_EACH), .INVERSE(1'b0)) dut_sc (
      .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_re(a_re), .in_im(a_im),
      .tw_re(t_re), .tw_im(t_im), .out_vld(vs), .out_re(os_re), .out_im(os_im));

   r4_stage #(.SMP_W(16), .GROWTH(GROW_FREE), .INVERSE(1'b1)) dut_inv (
      .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_re(a_re), .in_im(a_im),
      .tw_re(t_re), .tw_im(t_im), .out_vld(vi), .out_re(oi_re), .out_im(oi_im));

   r4_stage #(.SMP_W(16), .GROWTH(GROW_CAPPED), .INVERSE(1'b0)) dut_lo (
      .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_re(a_re), .in_im(a_im),
      .tw_re(t_re), .tw_im(t_im), .out_vld(vl), .out_re(ol_re), .out_im(ol_im));

   r4_stage #(.SMP_W(26), .GROWTH(GROW_CAPPED), .INVERSE(1'b1)) dut_cap (
      .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_re(b_re), .in_im(b_im),
      .tw_re(t_re), .tw_im(t_im), .out_vld(vc), .out_re(oc_re), .out_im(oc_im));

   typedef struct packed {
      logic [63:0]  a_re, a_im;
      logic [103:0] b_re, b_im;
      logic [71:0]  t_re, t_im;
      logic [31:0]  cyc;
   } vec_t;

   vec_t        q[$];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          cyc   = 0;
   bit          done  = 1'b0;
   logic [31:0] seed  = 32'h1234_5678;

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   function automatic longint sx(input longint v, input int w);
      longint m;
      m = v & ((64'sd1 <<< w) - 64'sd1);
      if (((m >>> (w - 1)) & 64'sd1) != 0) m = m - (64'sd1 <<< w);
      return m;
   endfunction

   function automatic longint lane_of(input logic [103:0] v, input int l, input int w);
      logic [103:0] t;
      t = v >> (l * w);
      return sx(longint'(t[63:0]), w);
   endfunction

   function automatic logic [63:0] pk16(input int x0, input int x1, input int x2, input int x3);
      return {x3[15:0], x2[15:0], x1[15:0], x0[15:0]};
   endfunction

   function automatic logic [71:0] pk18(input int x0, input int x1, input int x2, input int x3);
      return {x3[17:0], x2[17:0], x1[17:0], x0[17:0]};
   endfunction

   // 26-bit samples for the ceiling instance: scaled copy plus low filler bits.
   function automatic logic [103:0] up26(input logic [63:0] a, input logic [35:0] salt);
      logic [103:0] r;
      longint       v;
      r = '0;
      for (int l = 0; l < 4; l++) begin
         v = lane_of(104'(a), l, 16) * 512 + longint'((salt >> (l * 9)) & 36'h1ff);
         r[l*26 +: 26] = 26'(v);
      end
      return r;
   endfunction

   function automatic int twc(input int k);
      case (k & 7)
         0: return 65536;
         1: return 46341;
         2: return 0;
         3: return -46341;
         4: return -65536;
         5: return -46341;
         6: return 0;
         default: return 46341;
      endcase
   endfunction

   // Arithmetic reference of one stage, taken from the requirements.
   function automatic void model(input logic [103:0] sre, input logic [103:0] sim,
                                 input logic [71:0] tre, input logic [71:0] tim,
                                 input int w, input int ow, input int sh, input bit inv,
                                 output logic [107:0] xre, output logic [107:0] xim);
      longint yr[4], yi[4], zr[4], zi[4];
      longint ar, ai, br, bi, pr, pi;
      longint aa_r, aa_i, bb_r, bb_i, cc_r, cc_i, dd_r, dd_i;
      longint mr, mi, qr, qi, vr, vi;
      for (int l = 0; l < 4; l++) begin
         ar = lane_of(sre, l, w);
         ai = lane_of(sim, l, w);
         br = lane_of(104'(tre), l, 18);
         bi = lane_of(104'(tim), l, 18);
         if (inv) bi = -bi;
         pr = ar * br - ai * bi;
         pi = ar * bi + ai * br;
         yr[l] = sx(pr >>> 16, w);
         yi[l] = sx(pi >>> 16, w);
      end
      aa_r = yr[0] + yr[2]; aa_i = yi[0] + yi[2];
      bb_r = yr[0] - yr[2]; bb_i = yi[0] - yi[2];
      cc_r = yr[1] + yr[3]; cc_i = yi[1] + yi[3];
      dd_r = yr[1] - yr[3]; dd_i = yi[1] - yi[3];
      mr = bb_r + dd_i; mi = bb_i - dd_r;
      qr = bb_r - dd_i; qi = bb_i + dd_r;
      zr[0] = aa_r + cc_r; zi[0] = aa_i + cc_i;
      zr[2] = aa_r - cc_r; zi[2] = aa_i - cc_i;
      if (inv) begin
         zr[1] = qr; zi[1] = qi; zr[3] = mr; zi[3] = mi;
      end else begin
         zr[1] = mr; zi[1] = mi; zr[3] = qr; zi[3] = qi;
      end
      xre = '0;
      xim = '0;
      for (int l = 0; l < 4; l++) begin
         vr = sx(zr[l] >>> sh, ow) & ((64'sd1 <<< ow) - 64'sd1);
         vi = sx(zi[l] >>> sh, ow) & ((64'sd1 <<< ow) - 64'sd1);
         xre = xre | (108'(vr) << (l * ow));
         xim = xim | (108'(vi) << (l * ow));
      end
   endfunction

   task automatic chk(input string req, input string nm, input logic [107:0] got, input logic [107:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h (cycle %0d)", req, nm, got, exp, cyc);
      end
   endtask

   task automatic observe();
      vec_t         e;
      logic [107:0] xr, xi;
      chk("R1", "valid agreement", 108'({vs, vi, vl, vc}), 108'({4{va}}));
      if (va) begin
         if (q.size() == 0) begin
            chk("R10", "valid without input", 108'(1), 108'(0));
         end else begin
            e = q.pop_front();
            chk("R1", "latency", 108'(cyc - int'(e.cyc)), 108'(3));
            model(104'(e.a_re), 104'(e.a_im), e.t_re, e.t_im, 16, 18, 0, 1'b0, xr, xi);
            chk("R2 R3 R5", "free re", 108'(oa_re), xr);
            chk("R2 R3 R5", "free im", 108'(oa_im), xi);
            model(104'(e.a_re), 104'(e.a_im), e.t_re, e.t_im, 16, 16, 2, 1'b0, xr, xi);
            chk("R6", "shift re", 108'(os_re), xr);
            chk("R6", "shift im", 108'(os_im), xi);
            model(104'(e.a_re), 104'(e.a_im), e.t_re, e.t_im, 16, 18, 0, 1'b1, xr, xi);
            chk("R4", "inverse re", 108'(oi_re), xr);
            chk("R4", "inverse im", 108'(oi_im), xi);
            model(104'(e.a_re), 104'(e.a_im), e.t_re, e.t_im, 16, 18, 0, 1'b0, xr, xi);
            chk("R7", "capped low re", 108'(ol_re), xr);
            chk("R7", "capped low im", 108'(ol_im), xi);
            model(e.b_re, e.b_im, e.t_re, e.t_im, 26, 27, 1, 1'b1, xr, xi);
            chk("R8", "ceiling re", oc_re, xr);
            chk("R8", "ceiling im", oc_im, xi);
         end
      end else if (q.size() != 0 && cyc - int'(q[0].cyc) >= 3) begin
         chk("R1", "missing valid", 108'(0), 108'(1));
         void'(q.pop_front());
      end
   endtask

   task automatic tick();
      @(negedge clk);
      cyc++;
      observe();
   endtask

   task automatic send(input bit v, input logic [63:0] ar, input logic [63:0] ai,
                       input logic [103:0] br, input logic [103:0] bi,
                       input logic [71:0] tr, input logic [71:0] ti);
      vec_t e;
      tick();
      vld  = v;
      a_re = ar; a_im = ai; b_re = br; b_im = bi; t_re = tr; t_im = ti;
      if (v) begin
         e.a_re = ar; e.a_im = ai; e.b_re = br; e.b_im = bi;
         e.t_re = tr; e.t_im = ti; e.cyc = 32'(cyc);
         q.push_back(e);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [71:0] one_r, zero_t;
      rst_n = 1'b0;
      vld   = 1'b0;
      a_re = '0; a_im = '0; b_re = '0; b_im = '0; t_re = '0; t_im = '0;
      one_r  = pk18(65536, 65536, 65536, 65536);
      zero_t = '0;

      // R9: no valid while in reset, even with in_vld raised.
      repeat (2) begin
         @(negedge clk);
         chk("R9", "valid in reset", 108'(va | vs | vi | vl | vc), 108'(0));
      end
      vld = 1'b1;
      repeat (4) begin
         @(negedge clk);
         chk("R9", "valid in reset", 108'(va | vs | vi | vl | vc), 108'(0));
      end
      vld   = 1'b0;
      rst_n = 1'b1;

      // Directed patterns.
      send(1'b1, '0, '0, '0, '0, one_r, zero_t);
      send(1'b1, pk16(1000, 0, 0, 0), pk16(-700, 0, 0, 0),
           up26(pk16(1000, 0, 0, 0), 36'h0), up26(pk16(-700, 0, 0, 0), 36'h0), one_r, zero_t);
      send(1'b1, pk16(1000, 1000, 1000, 1000), '0,
           up26(pk16(1000, 1000, 1000, 1000), 36'h0), '0, one_r, zero_t);
      send(1'b1, pk16(-32768, -32768, -32768, -32768), pk16(-32768, -32768, -32768, -32768),
           up26(pk16(-32768, -32768, -32768, -32768), 36'hf_ffff_ffff),
           up26(pk16(-32768, -32768, -32768, -32768), 36'hf_ffff_ffff), one_r, zero_t);
      send(1'b1, pk16(0, 1000, 0, 0), '0, up26(pk16(0, 1000, 0, 0), 36'h0), '0, one_r, zero_t);
      send(1'b1, pk16(-32768, -32768, 5, -1), pk16(-32768, 7, -32768, 0),
           up26(pk16(-32768, -32768, 5, -1), 36'h0), up26(pk16(-32768, 7, -32768, 0), 36'h0),
           pk18(-65536, -65536, -65536, -65536), zero_t);
      send(1'b1, pk16(3, -3, 1, 2), pk16(-3, 3, -1, -2),
           up26(pk16(3, -3, 1, 2), 36'h1_2345_6789), up26(pk16(-3, 3, -1, -2), 36'h9_8765_4321),
           pk18(46341, 46341, 46341, 46341), pk18(46341, -46341, 46341, -46341));
      send(1'b1, pk16(1, 1, 1, 2), pk16(-1, -1, -1, -2), up26(pk16(1, 1, 1, 2), 36'h0),
           up26(pk16(-1, -1, -1, -2), 36'h0), one_r, zero_t);
      send(1'b1, pk16(1200, -800, 300, 4000), pk16(-50, 600, -7000, 90),
           up26(pk16(1200, -800, 300, 4000), 36'h0), up26(pk16(-50, 600, -7000, 90), 36'h0),
           pk18(0, 0, 0, 0), pk18(65536, -65536, 65536, -65536));

      // R10: gaps carrying live-looking data.
      send(1'b0, pk16(111, 222, 333, 444), pk16(5, 6, 7, 8), '1, '1, one_r, zero_t);
      send(1'b0, '1, '1, '1, '1, one_r, one_r);

      // Sweep with mixed table and arbitrary twiddles and irregular valid.
      for (int k = 0; k < 400; k++) begin
         logic [63:0]  sr, si;
         logic [35:0]  s1, s2;
         logic [71:0]  wr, wi;
         logic [31:0]  r;
         int           idx;
         sr = {rnd(), rnd()};
         si = {rnd(), rnd()};
         s1 = 36'({rnd(), rnd()});
         s2 = 36'({rnd(), rnd()});
         if (k % 3 == 1) begin
            sr = sr & 64'h0fff_0fff_0fff_0fff;
            si = si & 64'h00ff_00ff_00ff_00ff;
         end
         for (int l = 0; l < 4; l++) begin
            r = rnd();
            if (r[0]) begin
               idx = int'(r[7:5]);
               wr[l*18 +: 18] = 18'(twc(idx));
               wi[l*18 +: 18] = 18'(twc(idx + 2));
            end else begin
               wr[l*18 +: 18] = r[25:8];
               wi[l*18 +: 18] = rnd() >> 3;
            end
         end
         r = rnd();
         send(r[3:2] != 2'b00, sr, si, up26(sr, s1), up26(si, s2), wr, wi);
      end

      // Drain and confirm every accepted set came back (R1, R10).
      send(1'b0, '0, '0, '0, '0, zero_t, zero_t);
      repeat (6) tick();
      chk("R1", "pending results after drain", 108'(q.size()), 108'(0));

      done = 1'b1;
      summary();
      $finish;
   end

endmodule